// File: doc/BRIEF.md
# Heat-Bath Spin Update Pipeline

This block runs heat-bath Monte Carlo updates for a three-dimensional lattice of binary spins. A spin is one bit: 1 stands for up (+1), 0 for down (-1). Thirty-two spins share a word. The caller hands over one group at a time. A group is six 32-bit words holding the six lattice neighbours of 32 consecutive target spins. The block then works through the 32 bit positions, one per clock cycle.

For each position it takes the matching bit from every neighbour word and forms a 6-bit index. It reads an up-probability from a 64-entry table, which software loads beforehand. A 64-bit linear feedback shift register supplies a fresh random number for each update. The new spin is up when that number does not exceed the probability. The 32 new spins are packed into one result word, which appears on the output with a single-cycle strobe.

The table is held in two identical copies that serve alternate updates. This lets the lookup run at one update per cycle. A new group can be accepted during the cycle that consumes the last bit of the previous one, so a steady stream gives one result word every 32 cycles.

Top module: `hb_spin_update`

## Requirements
- R1: After reset `outValid` is 0, `inReady` is 1, every table entry reads 0, and the random generator state is 64'h9E3779B97F4A7C15.
- R2: For update i of a group (i = 0..31), index bit k is bit i of neighbour word k, where neighbour word k is `nbrWords[32k+31:32k]` (k = 0..5).
- R3: The new spin is 1 exactly when the 16-bit random value is less than or equal to the 16-bit table entry at the update's index, both compared as unsigned numbers. Equality gives 1.
- R4: The random generator is a 64-bit shift register that shifts toward the MSB. Its new bit 0 is s[63]^s[62]^s[60]^s[59]. It steps exactly once per update, in update order across groups. The random value of an update is bits [15:0] of the state after that step.
- R5: A cycle with `seedLoad` high loads `seed` into the generator. A seed of zero loads 64'h9E3779B97F4A7C15 instead.
- R6: Bits are consumed and packed least-significant first. Bit i of `outWord` is the new spin from update i.
- R7: Each accepted group yields exactly one `outWord`, in acceptance order, marked by a one-cycle `outValid` pulse. Pulses are at least 32 cycles apart.
- R8: `inReady` is high when no group is held, and also during the cycle that consumes bit 31 of the held group. It is low in the cycle after an accepted transfer. With `inValid` held high, successive groups are accepted exactly 32 cycles apart.
- R9: A table write (`tblWe` high) updates the entry at `tblAddr` in both copies. All updates that enter the lookup afterwards see the written value.
- R10: `outValid` rises 34 clock edges after the edge that accepts the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A neighbour group is offered |
| inReady | output | 1 | The block takes the offered group at this edge |
| nbrWords | input | 192 | Six packed neighbour words, word k in bits [32k+31:32k] |
| tblWe | input | 1 | Write strobe for the probability table |
| tblAddr | input | 6 | Table entry to write |
| tblData | input | 16 | Up-probability to store |
| seedLoad | input | 1 | Load the random generator seed |
| seed | input | 64 | Seed value, zero replaced by a fixed constant |
| outValid | output | 1 | One-cycle strobe for a finished result word |
| outWord | output | 32 | Packed new spins, bit i from update i |

## Verification
Two things can happen in the same cycle: a new group is accepted while the last bit of the previous group is being consumed. If that handover slipped, a cycle would be lost, or the bit would be taken from the wrong word. To provoke it, the bench keeps `inValid` high over several groups. It then checks that acceptances land exactly 32 cycles apart. The scoreboard also checks that each result word matches a model in which the random sequence runs on without a gap across the group boundary. Separately, the bench places a table value exactly equal to the next random value, to test the equality edge of the acceptance compare.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int WORD_W = 32;
  localparam int NBR_N  = 6;
  localparam int PROB_W = 16;
  localparam int LFSR_W = 64;
  localparam int POS_W  = $clog2(WORD_W);
  localparam logic [63:0] LFSR_INIT = 64'h9E3779B97F4A7C15;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic             load;  // latch a new neighbour group
    logic             upd;   // one update enters the pipeline
    logic             last;  // this update is bit WORD_W-1
    logic [POS_W-1:0] pos;   // bit position of this update
  } hbStrobe_t;
endpackage

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int WORDW = WORD_W
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output logic      inReady,
  output hbStrobe_t strobe
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORDW - 1);

  logic             busy;
  logic [POS_W-1:0] bitIdx;
  logic             lastBit;
  logic             take;

  assign lastBit = busy && (bitIdx == LAST_POS);
  assign inReady = !busy || lastBit;
  assign take    = inValid && inReady;

  always_comb begin
    strobe.load = take;
    strobe.upd  = busy;
    strobe.last = lastBit;
    strobe.pos  = bitIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitIdx <= '0;
    end else if (take) begin
      busy   <= 1'b1;
      bitIdx <= '0;
    end else if (busy) begin
      if (lastBit) busy <= 1'b0;
      else         bitIdx <= bitIdx + 1'b1;
    end
  end
endmodule

// File: rtl/hb_lfsr.sv
module hb_lfsr
  import hb_pkg::*;
#(
  parameter int STW  = LFSR_W,
  parameter int OUTW = PROB_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            seedLoad,
  input  logic [STW-1:0]  seed,
  input  logic            step,
  output logic [OUTW-1:0] rndNext
);
  logic [STW-1:0] state;
  logic [STW-1:0] nextState;
  logic           fb;

  // taps 64,63,61,60 give a maximal-length sequence
  assign fb        = state[STW-1] ^ state[STW-2] ^ state[STW-4] ^ state[STW-5];
  assign nextState = {state[STW-2:0], fb};
  assign rndNext   = nextState[OUTW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         state <= STW'(LFSR_INIT);
    else if (seedLoad) state <= (seed == '0) ? STW'(LFSR_INIT) : seed;
    else if (step)     state <= nextState;
  end
endmodule

// File: rtl/hb_datapath.sv
module hb_datapath
  import hb_pkg::*;
#(
  parameter int WORDW = WORD_W,
  parameter int NBRN  = NBR_N,
  parameter int PROBW = PROB_W,
  parameter int STW   = LFSR_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  hbStrobe_t              strobe,
  input  logic [NBRN*WORDW-1:0]  nbrWords,
  input  logic                   tblWe,
  input  logic [NBRN-1:0]        tblAddr,
  input  logic [PROBW-1:0]       tblData,
  input  logic                   seedLoad,
  input  logic [STW-1:0]         seed,
  output logic                   outValid,
  output logic [WORDW-1:0]       outWord
);
  localparam int TBL_D  = 1 << NBRN;
  localparam int COPIES = 2;

  // neighbour shift registers, bit 0 is the current update
  logic [WORDW-1:0] nbrSh [NBRN];
  logic [NBRN-1:0]  idxNow;

  for (genvar k = 0; k < NBRN; k++) begin : g_nbr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            nbrSh[k] <= '0;
      else if (strobe.load) nbrSh[k] <= nbrWords[k*WORDW +: WORDW];
      else if (strobe.upd)  nbrSh[k] <= nbrSh[k] >> 1;
    end
    assign idxNow[k] = nbrSh[k][0];
  end

  // stage 1: index formed
  logic             s1Valid, s1Last, s1Sel, selNext;
  logic [NBRN-1:0]  s1Idx;
  logic [POS_W-1:0] s1Pos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Last  <= 1'b0;
      s1Sel   <= 1'b0;
      selNext <= 1'b0;
      s1Idx   <= '0;
      s1Pos   <= '0;
    end else begin
      s1Valid <= strobe.upd;
      if (strobe.upd) begin
        s1Idx   <= idxNow;
        s1Last  <= strobe.last;
        s1Pos   <= strobe.pos;
        s1Sel   <= selNext;
        selNext <= ~selNext;
      end
    end
  end

  // duplicated probability table, copies serve alternate updates
  logic [PROBW-1:0] tbl [COPIES][TBL_D];
  logic [PROBW-1:0] probCopy [COPIES];

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int e = 0; e < TBL_D; e++) tbl[c][e] <= '0;
      end else if (tblWe) begin
        tbl[c][tblAddr] <= tblData;
      end
    end
    assign probCopy[c] = tbl[c][s1Idx];
  end

  // random source
  logic [PROBW-1:0] rndNext;

  hb_lfsr #(.STW(STW), .OUTW(PROBW)) u_lfsr (
    .clk      (clk),
    .rstN     (rstN),
    .seedLoad (seedLoad),
    .seed     (seed),
    .step     (s1Valid),
    .rndNext  (rndNext)
  );

  // stage 2: probability and random value
  logic             s2Valid, s2Last;
  logic [PROBW-1:0] s2Prob, s2Rnd;
  logic [POS_W-1:0] s2Pos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Valid <= 1'b0;
      s2Last  <= 1'b0;
      s2Prob  <= '0;
      s2Rnd   <= '0;
      s2Pos   <= '0;
    end else begin
      s2Valid <= s1Valid;
      if (s1Valid) begin
        s2Prob <= probCopy[s1Sel];
        s2Rnd  <= rndNext;
        s2Last <= s1Last;
        s2Pos  <= s1Pos;
      end
    end
  end

  // stage 3: compare and pack
  logic             newSpin;
  logic [WORDW-1:0] packReg, packNext;

  assign newSpin = (s2Rnd <= s2Prob);

  always_comb begin
    packNext        = packReg;
    packNext[s2Pos] = newSpin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      packReg  <= '0;
      outWord  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= s2Valid && s2Last;
      if (s2Valid) packReg <= packNext;
      if (s2Valid && s2Last) outWord <= packNext;
    end
  end
endmodule

// File: rtl/hb_spin_update.sv
module hb_spin_update
  import hb_pkg::*;
#(
  parameter int WORDW = WORD_W,
  parameter int NBRN  = NBR_N,
  parameter int PROBW = PROB_W,
  parameter int STW   = LFSR_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [NBRN*WORDW-1:0] nbrWords,
  input  logic                  tblWe,
  input  logic [NBRN-1:0]       tblAddr,
  input  logic [PROBW-1:0]      tblData,
  input  logic                  seedLoad,
  input  logic [STW-1:0]        seed,
  output logic                  outValid,
  output logic [WORDW-1:0]      outWord
);
  hbStrobe_t strobe;

  hb_ctrl #(.WORDW(WORDW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .strobe  (strobe)
  );

  hb_datapath #(.WORDW(WORDW), .NBRN(NBRN), .PROBW(PROBW), .STW(STW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .nbrWords (nbrWords),
    .tblWe    (tblWe),
    .tblAddr  (tblAddr),
    .tblData  (tblData),
    .seedLoad (seedLoad),
    .seed     (seed),
    .outValid (outValid),
    .outWord  (outWord)
  );
endmodule

// File: rtl/hb_checks.sv
module hb_checks #(
  parameter int WORDW = 32
) (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic outValid
);
  logic [2:0]  pending;
  logic [15:0] gap;
  logic        seenOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
      gap     <= '0;
      seenOut <= 1'b0;
    end else begin
      pending <= pending + 3'((inValid && inReady) ? 1 : 0) - 3'(outValid ? 1 : 0);
      if (outValid) begin
        gap     <= '0;
        seenOut <= 1'b1;
      end else if (gap != 16'hFFFF) begin
        gap <= gap + 1'b1;
      end
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady); // R8

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R7

  AST_OUT_HAS_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (pending != 0)); // R7

  AST_OUT_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && seenOut) |-> (gap >= 16'(WORDW - 1))); // R7
endmodule

bind hb_spin_update hb_checks #(.WORDW(WORDW)) u_checks (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid)
);

// File: tb/test_hb_spin_update.sv
`timescale 1ns/1ps
module test_hb_spin_update;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [191:0] nbrWords = '0;
  logic         tblWe = 1'b0;
  logic [5:0]   tblAddr = '0;
  logic [15:0]  tblData = '0;
  logic         seedLoad = 1'b0;
  logic [63:0]  seed = '0;
  logic         outValid;
  logic [31:0]  outWord;

  hb_spin_update i_hb_spin_update (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .nbrWords(nbrWords), .tblWe(tblWe), .tblAddr(tblAddr), .tblData(tblData),
    .seedLoad(seedLoad), .seed(seed), .outValid(outValid), .outWord(outWord)
  );

  always #2 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  bit doneFlag = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [31:0] word;
    int          acc;
    string       req;
    int          wantBit0;
  } item_t;
  item_t q[$];

  // reference model state
  logic [63:0] mLfsr = 64'h9E3779B97F4A7C15;
  logic [15:0] mTbl [64];
  initial for (int e = 0; e < 64; e++) mTbl[e] = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] stepL(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  function automatic logic [31:0] predict(input logic [191:0] w);
    logic [31:0] r;
    logic [5:0]  ix;
    for (int i = 0; i < 32; i++) begin
      for (int k = 0; k < 6; k++) ix[k] = w[32*k + i];
      mLfsr = stepL(mLfsr);
      r[i] = (mLfsr[15:0] <= mTbl[ix]);
    end
    return r;
  endfunction

  int lastAcc = -1000;

  task automatic sendGroup(input logic [191:0] w, input string req,
                           input int wantBit0, input bit b2b);
    item_t it;
    it.word = predict(w);
    it.req = req;
    it.wantBit0 = wantBit0;
    @(negedge clk);
    inValid = 1'b1;
    nbrWords = w;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1;
    it.acc = cyc;
    inValid = 1'b0;
    if (b2b) chk((cyc - lastAcc) == 32, "R8", "back-to-back accept spacing",
                 64'(cyc - lastAcc), 64'd32);
    lastAcc = cyc;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic writeTbl(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    tblWe = 1'b1; tblAddr = a; tblData = d;
    @(posedge clk);
    #1 tblWe = 1'b0;
    mTbl[a] = d;
  endtask

  task automatic loadSeed(input logic [63:0] s);
    @(negedge clk);
    seedLoad = 1'b1; seed = s;
    @(posedge clk);
    #1 seedLoad = 1'b0;
    mLfsr = (s == 64'd0) ? 64'h9E3779B97F4A7C15 : s;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7", "unexpected output word", 64'(outWord), 64'd0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(outWord == it.word, it.req, "result word", 64'(outWord), 64'(it.word));
        chk((cyc - it.acc) == 34, "R10", "accept to output latency",
            64'(cyc - it.acc), 64'd34);
        if (it.wantBit0 >= 0)
          chk(outWord[0] == it.wantBit0[0], "R3", "equality compare bit0",
              64'(outWord[0]), 64'(it.wantBit0));
      end
    end
  end

  function automatic logic [191:0] rnd192();
    return {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    logic [63:0] t;
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid in reset", 64'(outValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b1, "R1", "inReady after reset", 64'(inReady), 64'd1);
    chk(outValid == 1'b0, "R1", "outValid after reset", 64'(outValid), 64'd0);

    // R1: zero table and reset seed
    sendGroup(rnd192(), "R1", -1, 0);
    sendGroup({6{32'hFFFF_FFFF}}, "R1", -1, 0);
    drain();

    // R2 R6 R9: table encodes index parity, walking neighbour patterns
    for (int e = 0; e < 64; e++)
      writeTbl(6'(e), ($countones(6'(e)) % 2 == 1) ? 16'hFFFF : 16'h0000);
    sendGroup({32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0001}, "R6", -1, 0);
    sendGroup({32'h8000_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0}, "R2", -1, 0);
    sendGroup({32'hF0F0_F0F0, 32'h00FF_00FF, 32'h3333_3333,
               32'h5555_5555, 32'h0F0F_0F0F, 32'hAAAA_AAAA}, "R2", -1, 0);
    sendGroup(rnd192(), "R9", -1, 0);
    drain();
    for (int e = 0; e < 64; e++) writeTbl(6'(e), 16'($urandom()));
    sendGroup(rnd192(), "R9", -1, 0);
    sendGroup(rnd192(), "R3", -1, 0);
    drain();

    // R5: nonzero and zero seeds
    loadSeed(64'h0123_4567_89AB_CDEF);
    sendGroup(rnd192(), "R5", -1, 0);
    drain();
    loadSeed(64'd0);
    sendGroup(rnd192(), "R5", -1, 0);
    drain();

    // R7 R8 R4: continuous stream across group boundaries
    sendGroup(rnd192(), "R4", -1, 0);
    for (int g = 0; g < 5; g++) sendGroup(rnd192(), "R7", -1, 1);
    drain();

    // R3: probability equal to, then one below, the next random value
    t = stepL(mLfsr);
    writeTbl(6'd0, t[15:0]);
    sendGroup(192'd0, "R3", 1, 0);
    drain();
    t = stepL(mLfsr);
    if (t[15:0] != 16'd0) begin
      writeTbl(6'd0, t[15:0] - 16'd1);
      sendGroup(192'd0, "R3", 0, 0);
      drain();
    end

    doneFlag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!doneFlag) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule